// File: doc/BRIEF.md
# Restoring Sequential Integer Divider

This block divides one unsigned integer by another over several clock cycles and returns both the quotient and the remainder. It uses restoring shift-and-subtract and resolves one quotient bit per cycle. Each step moves the partial remainder left by one place and feeds in the next dividend bit. The step then tries to subtract the divisor. If the difference is not negative, the step keeps it and records a quotient 1. If the difference is negative, the step keeps the shifted remainder and records a 0.

Before the first step, the block counts the leading zeros of the dividend. It pre-aligns the dividend by that count and runs only one step per remaining significant bit, so small dividends finish sooner than large ones. A zero divisor and a zero dividend both skip the iteration loop and finish on the cycle after the request.

A client pulses the start input with the operands while the block is idle. It then waits for the one-cycle done pulse. The results stay on the outputs until the next accepted request.

Top module: `seq_divider`

## Requirements
- R1: While reset is asserted and on the first cycle after it, busy and done are low and quotient, remainder and the zero-divisor flag read 0.
- R2: A start pulse is accepted only when busy is low; a start pulse while busy is high does not change the result of the division in progress.
- R3: For a nonzero divisor, the quotient equals the dividend divided by the divisor rounded down, and the remainder equals the dividend minus quotient times divisor, which is always less than the divisor.
- R4: For a zero divisor, the zero-divisor flag is 1, the quotient is all ones, the remainder equals the dividend, and done rises on the first cycle after the start.
- R5: For a zero dividend and a nonzero divisor, quotient and remainder are 0, the zero-divisor flag is 0, and done rises on the first cycle after the start.
- R6: For nonzero dividend and divisor, done rises WIDTH − L + 1 cycles after the start is sampled, where L is the number of leading zero bits of the dividend.
- R7: Busy is high on every cycle from the cycle after an accepted start up to, but not including, the cycle in which done is high; busy is low whenever done is high.
- R8: Done is high for exactly one cycle per accepted start, and quotient, remainder and the zero-divisor flag hold their values from that cycle until the next accepted start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| start_i | input | 1 | Request strobe, sampled while idle |
| dividend_i | input | WIDTH | Unsigned dividend, sampled with start |
| divisor_i | input | WIDTH | Unsigned divisor, sampled with start |
| busy_o | output | 1 | Division in progress |
| done_o | output | 1 | One-cycle pulse when results are valid |
| quotient_o | output | WIDTH | Quotient |
| remainder_o | output | WIDTH | Remainder |
| div_zero_o | output | 1 | Divisor was zero |

## Verification
On every cycle, the bound checker enforces the arithmetic identity and the bound on the remainder whenever a nonzero-divisor result completes. It also enforces the fixed values returned for a zero divisor, the exclusion between busy and done, the single-cycle done pulse, and an upper bound on how long busy lasts. Only the bench scenarios can show the exact latency for each leading-zero count, the one-cycle finish for a zero dividend, and that a start arriving mid-division is ignored. The bench covers every dividend and divisor pair of a 6-bit build, so every pre-skip amount and every divisor value is reached.

// File: rtl/div_pkg.sv
package div_pkg;
  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_RUN  = 1'b1
  } div_state_e;
endpackage

// File: rtl/div_lzc.sv
module div_lzc #(
  parameter int W  = 32,
  parameter int CW = $clog2(W + 1)
) (
  input  logic [W-1:0]  val_i,
  output logic [CW-1:0] zeros_o
);
  always_comb begin
    zeros_o = CW'(W);
    for (int i = 0; i < W; i++) begin
      if (val_i[i]) zeros_o = CW'(W - 1 - i);
    end
  end
endmodule

// File: rtl/div_step.sv
module div_step #(
  parameter int W = 32
) (
  input  logic [W-1:0] rem_i,
  input  logic [W-1:0] dend_i,
  input  logic [W-1:0] quo_i,
  input  logic [W-1:0] dvs_i,
  output logic [W-1:0] rem_o,
  output logic [W-1:0] dend_o,
  output logic [W-1:0] quo_o
);
  logic [W:0]   shifted;
  logic [W+1:0] trial;
  logic         neg;

  always_comb begin
    shifted = {rem_i, dend_i[W-1]};
    trial   = {1'b0, shifted} - {2'b00, dvs_i};
    neg     = trial[W+1];
    rem_o   = neg ? shifted[W-1:0] : trial[W-1:0];
    quo_o   = {quo_i[W-2:0], ~neg};
    dend_o  = {dend_i[W-2:0], 1'b0};
  end
endmodule

// File: rtl/seq_divider.sv
module seq_divider #(
  parameter int WIDTH = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic [WIDTH-1:0] dividend_i,
  input  logic [WIDTH-1:0] divisor_i,
  output logic             busy_o,
  output logic             done_o,
  output logic [WIDTH-1:0] quotient_o,
  output logic [WIDTH-1:0] remainder_o,
  output logic             div_zero_o
);
  import div_pkg::*;

  localparam int CW = $clog2(WIDTH + 1);

  // reset release synchroniser
  logic rst_meta_q, rst_sync_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_q <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_q <= rst_meta_q;
    end
  end

  div_state_e       state_q, state_d;
  logic [CW-1:0]    cnt_q, cnt_d;
  logic [WIDTH-1:0] rem_q, rem_d, quo_q, quo_d, dend_q, dend_d, dvs_q, dvs_d;
  logic             done_q, done_d, dz_q, dz_d;
  logic             en;

  logic [CW-1:0]    lz;
  logic [WIDTH-1:0] st_rem, st_quo, st_dend;

  div_lzc #(.W(WIDTH), .CW(CW)) u_lzc (
    .val_i   (dividend_i),
    .zeros_o (lz)
  );

  div_step #(.W(WIDTH)) u_step (
    .rem_i  (rem_q),
    .dend_i (dend_q),
    .quo_i  (quo_q),
    .dvs_i  (dvs_q),
    .rem_o  (st_rem),
    .dend_o (st_dend),
    .quo_o  (st_quo)
  );

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    rem_d   = rem_q;
    quo_d   = quo_q;
    dend_d  = dend_q;
    dvs_d   = dvs_q;
    dz_d    = dz_q;
    done_d  = 1'b0;
    en      = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (start_i) begin
          en   = 1'b1;
          dz_d = (divisor_i == '0);
          if (divisor_i == '0) begin
            quo_d  = '1;
            rem_d  = dividend_i;
            done_d = 1'b1;
          end else if (dividend_i == '0) begin
            quo_d  = '0;
            rem_d  = '0;
            done_d = 1'b1;
          end else begin
            state_d = ST_RUN;
            quo_d   = '0;
            rem_d   = '0;
            dvs_d   = divisor_i;
            dend_d  = dividend_i << lz;
            cnt_d   = CW'(WIDTH) - lz;
          end
        end
      end
      ST_RUN: begin
        en     = 1'b1;
        rem_d  = st_rem;
        quo_d  = st_quo;
        dend_d = st_dend;
        cnt_d  = cnt_q - 1'b1;
        if (cnt_q == CW'(1)) begin
          state_d = ST_IDLE;
          done_d  = 1'b1;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_sync_q) begin
    if (!rst_sync_q) begin
      state_q <= ST_IDLE;
      done_q  <= 1'b0;
      cnt_q   <= '0;
      rem_q   <= '0;
      quo_q   <= '0;
      dend_q  <= '0;
      dvs_q   <= '0;
      dz_q    <= 1'b0;
    end else begin
      state_q <= state_d;
      done_q  <= done_d;
      if (en) begin
        cnt_q  <= cnt_d;
        rem_q  <= rem_d;
        quo_q  <= quo_d;
        dend_q <= dend_d;
        dvs_q  <= dvs_d;
        dz_q   <= dz_d;
      end
    end
  end

  assign busy_o      = (state_q == ST_RUN);
  assign done_o      = done_q;
  assign quotient_o  = quo_q;
  assign remainder_o = rem_q;
  assign div_zero_o  = dz_q;
endmodule

// File: rtl/div_checker.sv
module div_checker #(
  parameter int W = 32
) (
  input logic         clk,
  input logic         rst_n,
  input logic         start_i,
  input logic [W-1:0] dividend_i,
  input logic [W-1:0] divisor_i,
  input logic         busy_o,
  input logic         done_o,
  input logic [W-1:0] quotient_o,
  input logic [W-1:0] remainder_o,
  input logic         div_zero_o
);
  localparam int CW = $clog2(W + 1);

  logic [W-1:0]   cap_dvd, cap_dvs;
  logic [CW-1:0]  run_len;
  logic [2*W-1:0] recon, dvd_wide;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cap_dvd <= '0;
      cap_dvs <= '0;
      run_len <= '0;
    end else begin
      if (start_i && !busy_o) begin
        cap_dvd <= dividend_i;
        cap_dvs <= divisor_i;
      end
      if (busy_o) run_len <= run_len + 1'b1;
      else        run_len <= '0;
    end
  end

  assign recon    = {{W{1'b0}}, quotient_o} * {{W{1'b0}}, cap_dvs} + {{W{1'b0}}, remainder_o};
  assign dvd_wide = {{W{1'b0}}, cap_dvd};

  // R3
  a_r3_identity: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && !div_zero_o) |-> (recon == dvd_wide && remainder_o < cap_dvs));

  // R4
  a_r4_zero_divisor: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && div_zero_o) |-> (quotient_o == '1 && remainder_o == cap_dvd && cap_dvs == '0));

  // R7
  a_r7_busy_done_excl: assert property (@(posedge clk) disable iff (!rst_n)
    !(busy_o && done_o));

  // R7
  a_r7_busy_ends_in_done: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy_o) |-> done_o);

  // R8
  a_r8_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  // R6
  a_r6_latency_bound: assert property (@(posedge clk) disable iff (!rst_n)
    busy_o |-> (run_len < CW'(W)));
endmodule

bind seq_divider div_checker #(.W(WIDTH)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .start_i     (start_i),
  .dividend_i  (dividend_i),
  .divisor_i   (divisor_i),
  .busy_o      (busy_o),
  .done_o      (done_o),
  .quotient_o  (quotient_o),
  .remainder_o (remainder_o),
  .div_zero_o  (div_zero_o)
);

// File: tb/sim_seq_divider.sv
module sim_seq_divider;
  localparam int W    = 6;
  localparam int MAXV = (1 << W) - 1;

  logic         clk;
  logic         rst_n;
  logic         start_i;
  logic [W-1:0] dividend_i, divisor_i;
  logic         busy_o, done_o, div_zero_o;
  logic [W-1:0] quotient_o, remainder_o;

  int n_tests;
  int n_fail;

  seq_divider #(.WIDTH(W)) u0 (
    .clk(clk), .rst_n(rst_n), .start_i(start_i),
    .dividend_i(dividend_i), .divisor_i(divisor_i),
    .busy_o(busy_o), .done_o(done_o),
    .quotient_o(quotient_o), .remainder_o(remainder_o),
    .div_zero_o(div_zero_o)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int lead_zeros(input int v);
    int z = W;
    for (int i = 0; i < W; i++) if (v[i]) z = W - 1 - i;
    return z;
  endfunction

  // drives one request and waits for done; returns latency in cycles
  task automatic issue(input int n, input int d, output int lat, output bit busy_bad);
    @(negedge clk);
    start_i    = 1'b1;
    dividend_i = W'(n);
    divisor_i  = W'(d);
    @(negedge clk);
    start_i  = 1'b0;
    lat      = 1;
    busy_bad = 1'b0;
    while (!done_o && lat < W + 4) begin
      if (!busy_o) busy_bad = 1'b1;
      @(negedge clk);
      lat++;
    end
  endtask

  task automatic run_one(input int n, input int d);
    int  lat, exp_lat, eq, er;
    bit  bb;
    issue(n, d, lat, bb);
    if (d == 0) begin
      chk(div_zero_o == 1'b1, "R4 flag", int'(div_zero_o), 1);
      chk(quotient_o == W'(MAXV) && remainder_o == W'(n), "R4 values",
          int'(quotient_o) * 1000 + int'(remainder_o), MAXV * 1000 + n);
      chk(lat == 1, "R4 latency", lat, 1);
    end else begin
      eq = n / d;
      er = n % d;
      exp_lat = (n == 0) ? 1 : (W - lead_zeros(n) + 1);
      chk(int'(quotient_o) == eq, (n == 0) ? "R5 quotient" : "R3 quotient", int'(quotient_o), eq);
      chk(int'(remainder_o) == er, (n == 0) ? "R5 remainder" : "R3 remainder", int'(remainder_o), er);
      chk(int'(quotient_o) * d + int'(remainder_o) == n && int'(remainder_o) < d,
          "R3 identity", int'(quotient_o) * d + int'(remainder_o), n);
      chk(div_zero_o == 1'b0, "R3 flag clear", int'(div_zero_o), 0);
      chk(lat == exp_lat, (n == 0) ? "R5 latency" : "R6 latency", lat, exp_lat);
    end
    chk(!bb && !busy_o, "R7 busy window", int'(bb) * 10 + int'(busy_o), 0);
  endtask

  initial begin
    #(20 * 150000);
    n_fail++;
    n_tests++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    int  lat;
    bit  bb;
    logic [W-1:0] hq, hr;
    n_tests    = 0;
    n_fail     = 0;
    rst_n      = 1'b0;
    start_i    = 1'b0;
    dividend_i = '0;
    divisor_i  = '0;
    repeat (3) @(negedge clk);
    chk(!busy_o && !done_o && quotient_o == 0 && remainder_o == 0 && !div_zero_o,
        "R1 reset", int'(busy_o) + int'(done_o) + int'(quotient_o) + int'(remainder_o), 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk(!busy_o && !done_o && quotient_o == 0 && !div_zero_o, "R1 after release",
        int'(busy_o) + int'(done_o) + int'(quotient_o), 0);

    // directed example: 29 / 3
    run_one(29, 3);

    // R2: a start while busy is ignored
    @(negedge clk);
    start_i = 1'b1; dividend_i = W'(45); divisor_i = W'(7);
    @(negedge clk);
    start_i = 1'b0;
    @(negedge clk);
    start_i = 1'b1; dividend_i = W'(13); divisor_i = W'(2);
    @(negedge clk);
    start_i = 1'b0;
    lat = 0;
    while (!done_o && lat < W + 4) begin @(negedge clk); lat++; end
    chk(quotient_o == W'(6) && remainder_o == W'(3), "R2 busy start ignored",
        int'(quotient_o) * 100 + int'(remainder_o), 603);

    // R8: single pulse and held outputs
    hq = quotient_o;
    hr = remainder_o;
    repeat (4) @(negedge clk);
    chk(!done_o, "R8 done pulse", int'(done_o), 0);
    chk(quotient_o == hq && remainder_o == hr, "R8 hold",
        int'(quotient_o) * 100 + int'(remainder_o), int'(hq) * 100 + int'(hr));

    // exhaustive sweep
    for (int n = 0; n <= MAXV; n++) begin
      for (int d = 0; d <= MAXV; d++) begin
        run_one(n, d);
      end
    end

    // back-to-back requests, including zero divisor between nonzero ones
    issue(63, 0, lat, bb);
    chk(div_zero_o && remainder_o == W'(63), "R4 after sweep", int'(remainder_o), 63);
    run_one(63, 1);
    run_one(1, 63);

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule